// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM

This block is a 9-bit-wide synchronous RAM with two fully independent ports, each running on its own clock. Either port can read or write any word at any time. On every rising edge of its clock, a port samples its chip selects, its write strobe, its write data and its address-control inputs. The word it touches is chosen by a per-port burst address unit. That unit can clear to zero, load the external address, step by one or hold.

Reads come out in one of two latencies, picked per port by a mode input. In flow-through mode the data follows the edge that sampled the request. In pipelined mode the data passes through one more register stage. The read data is paired with a valid flag that stands in for a pad drive enable. That flag is gated at once by an active-low output enable that does not wait for a clock.

The depth is set by `ADDR_W`. The default is 10 bits, which keeps elaboration light. 13 or 14 bits give the 8K and 16K word arrays.

Top module: `dpr_true_dual`

## Requirements
- R1: A port performs an access only when its `ce_lo_n` is 0 and its `ce_hi` is 1. With any other combination it writes nothing, and the read valid for that cycle stays 0.
- R2: A selected access with `wr_n` = 0 stores `wdata` into the access word. The valid flag stays 0 for that access.
- R3: With `pipe` = 0 at the request edge, a selected read with `wr_n` = 1 shows `q_vld` = 1 and the word on `q` right after that same edge.
- R4: With `pipe` = 1, the read result appears one edge later. After the request edge the output still carries the previous stage.
- R5: `oe_n` = 1 forces `q_vld` and `q` to 0 at once, with no clock edge needed. `oe_n` = 0 restores the held result.
- R6: `q` is all zeros whenever `q_vld` is 0.
- R7: `clr_n` = 0 makes the access address 0 and clears the counter. This overrides `ld_n` and `step_n`, and it acts whether or not the port is selected.
- R8: With `clr_n` = 1 and `ld_n` = 0, the external `addr` is the access address and is stored in the counter.
- R9: With `clr_n` = `ld_n` = 1 and `step_n` = 0, the access address is the counter plus one. It wraps from the top word to 0, and it advances even when the port is deselected.
- R10: With `clr_n`, `ld_n` and `step_n` all 1, the access address is the stored counter value, unchanged.
- R11: A word written through one port is returned by a read on the other port at that port's first request edge after the write edge.
- R12: If the right port's edge comes while the left port presents a selected write to the same access address, the right write is dropped. The left data is kept.
- R13: Reset clears both counters to 0 and both valid flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| l_ce_lo_n | input | 1 | Left chip select, active low |
| l_ce_hi | input | 1 | Left chip select, active high |
| l_wr_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low, unclocked |
| l_pipe | input | 1 | Left read mode, 0 = flow-through, 1 = pipelined |
| l_ld_n | input | 1 | Left counter load from `l_addr`, active low |
| l_step_n | input | 1 | Left counter increment, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_addr | input | ADDR_W | Left external address |
| l_wdata | input | DATA_W | Left write data |
| l_q | output | DATA_W | Left read data |
| l_q_vld | output | 1 | Left read valid / drive enable |
| r_ce_lo_n | input | 1 | Right chip select, active low |
| r_ce_hi | input | 1 | Right chip select, active high |
| r_wr_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low, unclocked |
| r_pipe | input | 1 | Right read mode, 0 = flow-through, 1 = pipelined |
| r_ld_n | input | 1 | Right counter load from `r_addr`, active low |
| r_step_n | input | 1 | Right counter increment, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_addr | input | ADDR_W | Right external address |
| r_wdata | input | DATA_W | Right write data |
| r_q | output | DATA_W | Right read data |
| r_q_vld | output | 1 | Right read valid / drive enable |

## Verification
A flow-through read result is due one edge of the requesting port's own clock after the request is sampled. A pipelined result is due two edges after it. Writes, counter updates and deselects settle at that first edge. Output-enable changes act within the same half period. The bench drives each port on the falling edge of its own clock and samples on the following falling edge. For pipelined reads it also samples the intermediate edge, expecting an idle output there, so that a result arriving early or late fails. The two clocks have periods of 10 and 14 ns, so a rising edge on one never lands on a falling edge of the other. Cross-port reads are issued only after the write edge has passed. The collision case holds both requests across one edge of each clock.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    CNT_CLEAR = 2'd0,
    CNT_LOAD  = 2'd1,
    CNT_STEP  = 2'd2,
    CNT_KEEP  = 2'd3
  } cnt_op_e;

  // Priority: clear beats load, load beats step, otherwise keep.
  function automatic cnt_op_e cnt_decode(input logic clr_n, input logic ld_n,
                                         input logic step_n);
    if (!clr_n)  return CNT_CLEAR;
    if (!ld_n)   return CNT_LOAD;
    if (!step_n) return CNT_STEP;
    return CNT_KEEP;
  endfunction

  // Port is live only for the one active combination of its two selects.
  function automatic logic port_on(input logic ce_lo_n, input logic ce_hi);
    return !ce_lo_n && ce_hi;
  endfunction

endpackage

// File: rtl/dpr_addr_unit.sv
module dpr_addr_unit #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          step_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cnt_q
);
  import dpr_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  cnt_op_e op;
  assign op = cnt_decode(clr_n, ld_n, step_n);

  always_comb begin
    case (op)
      CNT_CLEAR: acc_addr = '0;
      CNT_LOAD:  acc_addr = ext_addr;
      CNT_STEP:  acc_addr = cnt_q + ONE;
      default:   acc_addr = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= acc_addr;
  end

endmodule

// File: rtl/dpr_read_path.sv
module dpr_read_path #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          pipe,
  input  logic          oe_n,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] q,
  output logic          q_vld
);
  logic          st1_v, st2_v, mode_q;
  logic [DW-1:0] st1_d, st2_d;
  logic          sel_v;
  logic [DW-1:0] sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_v  <= 1'b0;
      st2_v  <= 1'b0;
      mode_q <= 1'b0;
      st1_d  <= '0;
      st2_d  <= '0;
    end else begin
      st1_v  <= rd_req;
      st1_d  <= word;
      st2_v  <= st1_v;
      st2_d  <= st1_d;
      mode_q <= pipe;
    end
  end

  assign sel_v = mode_q ? st2_v : st1_v;
  assign sel_d = mode_q ? st2_d : st1_d;
  assign q_vld = sel_v && !oe_n;
  assign q     = q_vld ? sel_d : '0;

endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_lo_n,
  input  logic          ce_hi,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic          pipe,
  input  logic          ld_n,
  input  logic          step_n,
  input  logic          clr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] acc_addr,
  output logic          wr_en,
  output logic [AW-1:0] cnt,
  output logic [DW-1:0] q,
  output logic          q_vld
);
  import dpr_pkg::*;

  logic sel;
  assign sel   = port_on(ce_lo_n, ce_hi);
  assign wr_en = sel && !wr_n;

  dpr_addr_unit #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .step_n   (step_n),
    .ext_addr (addr),
    .acc_addr (acc_addr),
    .cnt_q    (cnt)
  );

  dpr_read_path #(.DW(DW)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (sel && wr_n),
    .pipe   (pipe),
    .oe_n   (oe_n),
    .word   (word),
    .q      (q),
    .q_vld  (q_vld)
  );

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk_l,
  input  logic          clk_r,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_word,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_word,
  output logic          r_drop
);
  localparam int DEPTH = 1 << AW;
  localparam int NP    = 2;

  logic [DW-1:0]    bank_l [DEPTH];
  logic [DW-1:0]    bank_r [DEPTH];
  logic [DEPTH-1:0] tag_l, tag_r;

  // Left wins: a right write aimed where the left is writing is discarded.
  assign r_drop = r_we && l_we && (r_addr == l_addr);

  // Equal tags mark the left bank as newest; a left write copies the right tag.
  always_ff @(posedge clk_l) begin
    if (l_we) begin
      bank_l[l_addr] <= l_wdata;
      tag_l[l_addr]  <= tag_r[l_addr];
    end
  end

  // A right write makes the tags differ, marking the right bank as newest.
  always_ff @(posedge clk_r) begin
    if (r_we && !r_drop) begin
      bank_r[r_addr] <= r_wdata;
      tag_r[r_addr]  <= ~tag_l[r_addr];
    end
  end

  logic [AW-1:0] rd_a [NP];
  logic [DW-1:0] rd_w [NP];
  assign rd_a[0] = l_addr;
  assign rd_a[1] = r_addr;

  for (genvar p = 0; p < NP; p++) begin : g_pick
    assign rd_w[p] = (tag_l[rd_a[p]] == tag_r[rd_a[p]]) ? bank_l[rd_a[p]]
                                                        : bank_r[rd_a[p]];
  end

  assign l_word = rd_w[0];
  assign r_word = rd_w[1];

endmodule

// File: rtl/dpr_true_dual.sv
module dpr_true_dual #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              l_ce_lo_n,
  input  logic              l_ce_hi,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic              l_pipe,
  input  logic              l_ld_n,
  input  logic              l_step_n,
  input  logic              l_clr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_q,
  output logic              l_q_vld,
  input  logic              r_ce_lo_n,
  input  logic              r_ce_hi,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic              r_pipe,
  input  logic              r_ld_n,
  input  logic              r_step_n,
  input  logic              r_clr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_q,
  output logic              r_q_vld
);
  logic [ADDR_W-1:0] l_acc, r_acc, l_cnt, r_cnt;
  logic              l_we, r_we, r_drop;
  logic [DATA_W-1:0] l_word, r_word;

  dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_left (
    .clk (clk_l), .rst_n (rst_n),
    .ce_lo_n (l_ce_lo_n), .ce_hi (l_ce_hi), .wr_n (l_wr_n), .oe_n (l_oe_n),
    .pipe (l_pipe), .ld_n (l_ld_n), .step_n (l_step_n), .clr_n (l_clr_n),
    .addr (l_addr), .word (l_word), .acc_addr (l_acc), .wr_en (l_we),
    .cnt (l_cnt), .q (l_q), .q_vld (l_q_vld)
  );

  dpr_port #(.AW(ADDR_W), .DW(DATA_W)) u_right (
    .clk (clk_r), .rst_n (rst_n),
    .ce_lo_n (r_ce_lo_n), .ce_hi (r_ce_hi), .wr_n (r_wr_n), .oe_n (r_oe_n),
    .pipe (r_pipe), .ld_n (r_ld_n), .step_n (r_step_n), .clr_n (r_clr_n),
    .addr (r_addr), .word (r_word), .acc_addr (r_acc), .wr_en (r_we),
    .cnt (r_cnt), .q (r_q), .q_vld (r_q_vld)
  );

  dpr_storage #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk_l (clk_l), .clk_r (clk_r),
    .l_we (l_we), .l_addr (l_acc), .l_wdata (l_wdata), .l_word (l_word),
    .r_we (r_we), .r_addr (r_acc), .r_wdata (r_wdata), .r_word (r_word),
    .r_drop (r_drop)
  );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input logic          clk_l,
  input logic          clk_r,
  input logic          rst_n,
  input logic          l_ce_lo_n, l_ce_hi, l_wr_n, l_oe_n, l_pipe,
  input logic          l_ld_n, l_step_n, l_clr_n,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_q,
  input logic          l_q_vld,
  input logic [AW-1:0] l_cnt,
  input logic          r_ce_lo_n, r_ce_hi, r_wr_n, r_oe_n, r_pipe,
  input logic          r_ld_n, r_step_n, r_clr_n,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_q,
  input logic          r_q_vld,
  input logic [AW-1:0] r_cnt,
  input logic          r_drop
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // ---- left port ----
  p_desel_r1_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!(!l_ce_lo_n && l_ce_hi) && !l_pipe) |=> !l_q_vld);
  p_write_mute_r2_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!l_ce_lo_n && l_ce_hi && !l_wr_n && !l_pipe) |=> !l_q_vld);
  p_oe_gate_r5_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    l_oe_n |-> !l_q_vld);
  p_zero_idle_r6_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    !l_q_vld |-> (l_q == '0));
  p_clear_r7_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    !l_clr_n |=> (l_cnt == '0));
  p_load_r8_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (l_clr_n && !l_ld_n) |=> (l_cnt == $past(l_addr)));
  p_step_r9_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (l_clr_n && l_ld_n && !l_step_n) |=> (l_cnt == $past(l_cnt) + ONE));
  p_keep_r10_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (l_clr_n && l_ld_n && l_step_n) |=> $stable(l_cnt));

  // ---- right port ----
  p_desel_r1_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (!(!r_ce_lo_n && r_ce_hi) && !r_pipe) |=> !r_q_vld);
  p_write_mute_r2_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (!r_ce_lo_n && r_ce_hi && !r_wr_n && !r_pipe) |=> !r_q_vld);
  p_oe_gate_r5_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    r_oe_n |-> !r_q_vld);
  p_zero_idle_r6_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    !r_q_vld |-> (r_q == '0));
  p_clear_r7_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    !r_clr_n |=> (r_cnt == '0));
  p_load_r8_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (r_clr_n && !r_ld_n) |=> (r_cnt == $past(r_addr)));
  p_step_r9_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (r_clr_n && r_ld_n && !r_step_n) |=> (r_cnt == $past(r_cnt) + ONE));
  p_keep_r10_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (r_clr_n && r_ld_n && r_step_n) |=> $stable(r_cnt));

  // A dropped right write needs a live left write at that moment.
  p_drop_cause_r12: assert property (@(posedge clk_r) disable iff (!rst_n)
    r_drop |-> (!l_ce_lo_n && l_ce_hi && !l_wr_n && !r_wr_n));

endmodule

bind dpr_true_dual dpr_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk_l (clk_l), .clk_r (clk_r), .rst_n (rst_n),
  .l_ce_lo_n (l_ce_lo_n), .l_ce_hi (l_ce_hi), .l_wr_n (l_wr_n), .l_oe_n (l_oe_n),
  .l_pipe (l_pipe), .l_ld_n (l_ld_n), .l_step_n (l_step_n), .l_clr_n (l_clr_n),
  .l_addr (l_addr), .l_q (l_q), .l_q_vld (l_q_vld), .l_cnt (l_cnt),
  .r_ce_lo_n (r_ce_lo_n), .r_ce_hi (r_ce_hi), .r_wr_n (r_wr_n), .r_oe_n (r_oe_n),
  .r_pipe (r_pipe), .r_ld_n (r_ld_n), .r_step_n (r_step_n), .r_clr_n (r_clr_n),
  .r_addr (r_addr), .r_q (r_q), .r_q_vld (r_q_vld), .r_cnt (r_cnt),
  .r_drop (r_drop)
);

// File: tb/dpr_true_dual_bench.sv
`timescale 1ns/1ps
module dpr_true_dual_bench;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int TOP = (1 << AW) - 1;

  logic clk_l = 1'b0, clk_r = 1'b0, rst_n = 1'b0;
  always #5 clk_l = ~clk_l;
  always #7 clk_r = ~clk_r;

  logic          l_ce_lo_n, l_ce_hi, l_wr_n, l_oe_n, l_pipe, l_ld_n, l_step_n, l_clr_n;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata, l_q;
  logic          l_q_vld;
  logic          r_ce_lo_n, r_ce_hi, r_wr_n, r_oe_n, r_pipe, r_ld_n, r_step_n, r_clr_n;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata, r_q;
  logic          r_q_vld;

  dpr_true_dual #(.ADDR_W(AW), .DATA_W(DW)) u_dpr_true_dual (
    .clk_l, .clk_r, .rst_n,
    .l_ce_lo_n, .l_ce_hi, .l_wr_n, .l_oe_n, .l_pipe, .l_ld_n, .l_step_n, .l_clr_n,
    .l_addr, .l_wdata, .l_q, .l_q_vld,
    .r_ce_lo_n, .r_ce_hi, .r_wr_n, .r_oe_n, .r_pipe, .r_ld_n, .r_step_n, .r_clr_n,
    .r_addr, .r_wdata, .r_q, .r_q_vld
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] model [1 << AW];

  typedef struct packed {
    logic          side;  // 0 = left, 1 = right
    logic          wr;
    logic          pp;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 1'b0, 10'd0,    9'h0A5},
    '{1'b1, 1'b1, 1'b0, 10'd1,    9'h15A},
    '{1'b0, 1'b1, 1'b0, 10'd2,    9'h1FF},
    '{1'b1, 1'b1, 1'b0, 10'd3,    9'h000},
    '{1'b0, 1'b1, 1'b0, 10'd1023, 9'h123},
    '{1'b1, 1'b1, 1'b0, 10'd512,  9'h0F0},
    '{1'b1, 1'b0, 1'b0, 10'd0,    9'h000},
    '{1'b0, 1'b0, 1'b0, 10'd1,    9'h000},
    '{1'b0, 1'b0, 1'b1, 10'd2,    9'h000},
    '{1'b1, 1'b0, 1'b1, 10'd1023, 9'h000},
    '{1'b0, 1'b0, 1'b1, 10'd512,  9'h000},
    '{1'b1, 1'b0, 1'b0, 10'd3,    9'h000},
    '{1'b1, 1'b1, 1'b0, 10'd2,    9'h055},
    '{1'b0, 1'b0, 1'b0, 10'd2,    9'h000},
    '{1'b0, 1'b1, 1'b0, 10'd3,    9'h1AA},
    '{1'b1, 1'b0, 1'b1, 10'd3,    9'h000}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got vld/q %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW:0] got(input bit s);
    return s ? {r_q_vld, r_q} : {l_q_vld, l_q};
  endfunction

  task automatic edge_of(input bit s);
    if (s) @(negedge clk_r);
    else   @(negedge clk_l);
  endtask

  task automatic set_port(input bit s, input logic ce_lo_n, input logic ce_hi,
                          input logic wr_n, input logic pp, input logic ld_n,
                          input logic step_n, input logic clr_n,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (s) begin
      r_ce_lo_n = ce_lo_n; r_ce_hi = ce_hi; r_wr_n = wr_n; r_pipe = pp;
      r_ld_n = ld_n; r_step_n = step_n; r_clr_n = clr_n; r_addr = a; r_wdata = d;
    end else begin
      l_ce_lo_n = ce_lo_n; l_ce_hi = ce_hi; l_wr_n = wr_n; l_pipe = pp;
      l_ld_n = ld_n; l_step_n = step_n; l_clr_n = clr_n; l_addr = a; l_wdata = d;
    end
  endtask

  task automatic idle(input bit s, input logic pp);
    set_port(s, 1'b1, 1'b1, 1'b1, pp, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic do_write(input bit s, input logic [AW-1:0] a, input logic [DW-1:0] d);
    edge_of(s);
    set_port(s, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, a, d);
    edge_of(s);
    idle(s, 1'b0);
    check("R2 write no valid", got(s), '0);
    model[a] = d;
  endtask

  task automatic do_read(input bit s, input logic pp, input logic ld_n,
                         input logic step_n, input logic clr_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input string req);
    edge_of(s);
    set_port(s, 1'b0, 1'b1, 1'b1, pp, ld_n, step_n, clr_n, a, '0);
    edge_of(s);
    idle(s, pp);
    if (!pp) begin
      check(req, got(s), {1'b1, exp});
    end else begin
      check({req, " R4 gap R6"}, got(s), '0);
      edge_of(s);
      check(req, got(s), {1'b1, exp});
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(1'b0, 1'b0); idle(1'b1, 1'b0);
    l_oe_n = 1'b0; r_oe_n = 1'b0;
    #23 rst_n = 1'b1;

    // R13: outputs idle after reset
    check("R13 left reset", got(1'b0), '0);
    check("R13 right reset", got(1'b1), '0);

    // Table walk: writes then cross-port reads in both modes (R3 R4 R8 R11)
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) do_write(TBL[i].side, TBL[i].a, TBL[i].d);
      else do_read(TBL[i].side, TBL[i].pp, 1'b0, 1'b1, 1'b1, TBL[i].a,
                   model[TBL[i].a], TBL[i].pp ? "R4 R8 R11 pipelined" : "R3 R8 R11 flow");
    end

    // R5: output enable acts without a clock
    edge_of(1'b0);
    set_port(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'd1, '0);
    edge_of(1'b0);
    idle(1'b0, 1'b0);
    l_oe_n = 1'b1; #1;
    check("R5 oe high", got(1'b0), '0);
    l_oe_n = 1'b0; #1;
    check("R5 oe low", got(1'b0), {1'b1, model[1]});

    // R1: deselected write ignored; deselected read gives no valid
    edge_of(1'b0);
    set_port(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd1, 9'h1EE);
    edge_of(1'b0);
    idle(1'b0, 1'b0);
    check("R1 ce_hi low write", got(1'b0), '0);
    do_read(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd1, model[1], "R1 word unchanged");
    edge_of(1'b1);
    set_port(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'd0, '0);
    edge_of(1'b1);
    idle(1'b1, 1'b0);
    check("R1 ce_lo high read", got(1'b1), '0);

    // R7: clear overrides load
    do_read(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd5, model[0], "R7 clear wins");
    // R9 step, R10 hold
    do_read(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd2, model[2], "R8 load");
    do_read(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd0, model[3], "R9 step");
    do_read(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0, model[3], "R10 hold");
    do_read(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, TOP[AW-1:0], model[TOP], "R8 load top");
    do_read(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd0, model[0], "R9 wrap");
    // R9: step while deselected still advances
    do_read(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd0, model[0], "R8 load zero");
    edge_of(1'b0);
    set_port(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, '0);
    edge_of(1'b0);
    idle(1'b0, 1'b0);
    do_read(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0, model[1], "R9 step while deselected");

    // R12: overlapping writes to one word, left data kept
    edge_of(1'b0);
    set_port(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd100, 9'h111);
    set_port(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd100, 9'h0EE);
    fork
      @(posedge clk_l);
      @(posedge clk_r);
    join
    #1;
    idle(1'b0, 1'b0); idle(1'b1, 1'b0);
    model[100] = 9'h111;
    do_read(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'd100, model[100], "R12 left wins");
    do_read(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd100, model[100], "R12 left wins");

    // R13: reset mid-run clears counters and valids
    do_read(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd3, model[3], "R8 preload");
    @(negedge clk_l); #2;
    rst_n = 1'b0;
    #1;
    check("R13 left valid in reset", got(1'b0), '0);
    #20 rst_n = 1'b1;
    do_read(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0, model[0], "R13 counter at zero");

    summary();
    $finish;
  end

endmodule